// File: doc/BRIEF.md
# Target Information Phase Sequencer

This block steps a bus target through the information-transfer phases once selection has completed. It drives the three phase lines (control/data, in/out, message) together with a busy line, and it hands every byte of every phase to a separate byte-transfer engine through a simple go/done handshake. The engine runs the request/acknowledge exchange on the bus. The sequencer only decides which phase is current, how many bytes it takes, and which byte it sends when the target is the source.

The order is fixed: the command block comes in first, then an optional data phase in the direction chosen by the back-end, then a one-byte status, then a command-complete message. The command length is taken from the group field of the operation code. The back-end supplies the data direction, the data byte count and the status byte. Between phases the sequencer holds the old phase lines until the bus acknowledge line has been negated. After the message it drops busy and all phase lines, which leaves the bus free.

Top module: `tpseq_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, bsy_o, cd_o, io_o, msg_o and xfer_go_o are all 0.
- R2: A one-cycle sel_done_i pulse while idle makes the next cycle show bsy_o=1, {cd_o,io_o,msg_o}=3'b100 (command phase, initiator to target) and xfer_go_o=1.
- R3: The command phase takes 6 bytes when bits [7:5] of the first received byte are 0, 10 bytes when they are 1 or 2, and 12 bytes when they are 5.
- R4: For any other value of bits [7:5], the command phase ends after that single byte, the data phase is skipped, and the status byte is 8'h02 whatever be_status_i holds.
- R5: The data phase shows cd_o=0, msg_o=0 and io_o equal to be_dir_in_i (1 means toward the initiator), and it moves exactly be_len_i bytes, sampled when the last command byte completes.
- R6: When be_len_i is 0 at that point, no data phase occurs and the status phase follows the command phase.
- R7: The status phase shows {cd_o,io_o,msg_o}=3'b110 and sends one byte equal to be_status_i (8'h00 means good, 8'h02 means check condition).
- R8: The message phase shows {cd_o,io_o,msg_o}=3'b111, sends one byte 8'h00, and then bsy_o and all three phase lines return to 0.
- R9: The phase lines change only in the cycle after one in which ack_i was 0. While ack_i stays 1 after the last byte of a phase, the lines keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_done_i | input | 1 | Pulse: selection finished, begin the command phase |
| ack_i | input | 1 | Bus acknowledge line as seen by the target, active high |
| xfer_done_i | input | 1 | Engine pulse: one byte of the current phase moved |
| xfer_rx_i | input | 8 | Byte received from the initiator, valid with xfer_done_i |
| be_dir_in_i | input | 1 | Data direction, 1 = toward the initiator |
| be_len_i | input | LEN_W | Data phase byte count |
| be_status_i | input | 8 | Completion status byte |
| xfer_go_o | output | 1 | Request to the engine to move a byte in the current phase |
| xfer_tx_o | output | 8 | Byte to send during status and message phases |
| bsy_o | output | 1 | Busy line, high while the target holds the bus |
| cd_o | output | 1 | Control/data phase line |
| io_o | output | 1 | In/out phase line |
| msg_o | output | 1 | Message phase line |

## Verification
The bench builds the block with its default LEN_W of 16. That width leaves every data count the bench uses far below the counter limit, so the runs focus on phase order, the length decode and ACK gating rather than on counter wrap. Data counts of 0, 1 and a few bytes reach the skipped-phase case and the single-byte last-byte case. The vectors cover opcodes from every length group and two unknown groups, and they hold ACK high for several cycles after each byte, so a phase change made before ACK negation would show on the lines.

// File: rtl/tpseq_pkg.sv
package tpseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_STAT,
    ST_MSG,
    ST_GAP
  } seq_state_t;

  // phase line codes, ordered {cd, io, msg}
  localparam logic [2:0] PH_FREE = 3'b000;
  localparam logic [2:0] PH_CMD  = 3'b100;
  localparam logic [2:0] PH_STAT = 3'b110;
  localparam logic [2:0] PH_MIN  = 3'b111;

  localparam logic [7:0] STS_CHECK = 8'h02;
  localparam logic [7:0] MSG_DONE  = 8'h00;

endpackage

// File: rtl/tpseq_len_decode.sv
module tpseq_len_decode (
  input  logic [7:0] opcode_i,
  output logic [3:0] len_o,
  output logic       ok_o
);

  always_comb begin
    ok_o  = 1'b1;
    unique case (opcode_i[7:5])
      3'd0:       len_o = 4'd6;
      3'd1, 3'd2: len_o = 4'd10;
      3'd5:       len_o = 4'd12;
      default: begin
        len_o = 4'd0;
        ok_o  = 1'b0;
      end
    endcase
  end

  // p_len_legal_r3: a known group never yields a length outside 6/10/12
  always_comb begin
    if (ok_o) begin
      p_len_legal_r3: assert (len_o == 4'd6 || len_o == 4'd10 || len_o == 4'd12);
    end
  end

endmodule

// File: rtl/tpseq_counter.sv
module tpseq_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;
  logic         cnt_en;
  logic [W-1:0] cnt_d;

  assign cnt_en = clr_i | inc_i;
  assign cnt_d  = clr_i ? '0 : cnt_q + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/tpseq_top.sv
module tpseq_top
  import tpseq_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_done_i,
  input  logic             ack_i,
  input  logic             xfer_done_i,
  input  logic [7:0]       xfer_rx_i,
  input  logic             be_dir_in_i,
  input  logic [LEN_W-1:0] be_len_i,
  input  logic [7:0]       be_status_i,
  output logic             xfer_go_o,
  output logic [7:0]       xfer_tx_o,
  output logic             bsy_o,
  output logic             cd_o,
  output logic             io_o,
  output logic             msg_o
);

  seq_state_t       state_q, state_d;
  seq_state_t       nxt_q, nxt_d;
  logic [2:0]       lines_q, lines_d;
  logic             bsy_q, bsy_d;
  logic             bad_q, bad_d;
  logic [3:0]       clen_q, clen_d;
  logic [LEN_W-1:0] dlen_q, dlen_d;
  logic             dir_q, dir_d;

  logic [LEN_W-1:0] cnt;
  logic             cnt_clr;
  logic             byte_done;
  logic [3:0]       dec_len;
  logic             dec_ok;
  logic             first_byte;
  logic             bad_now;
  logic             last_cmd;
  logic             last_data;

  tpseq_len_decode u_dec (
    .opcode_i (xfer_rx_i),
    .len_o    (dec_len),
    .ok_o     (dec_ok)
  );

  tpseq_counter #(.W(LEN_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .inc_i (byte_done),
    .cnt_o (cnt)
  );

  assign xfer_go_o  = (state_q == ST_CMD) || (state_q == ST_DATA) ||
                      (state_q == ST_STAT) || (state_q == ST_MSG);
  assign byte_done  = xfer_go_o && xfer_done_i;
  assign first_byte = (cnt == '0);
  assign bad_now    = first_byte ? !dec_ok : bad_q;
  assign last_cmd   = first_byte ? !dec_ok : (cnt + LEN_W'(1) == LEN_W'(clen_q));
  assign last_data  = (cnt + LEN_W'(1) == dlen_q);

  function automatic logic [2:0] lines_of(seq_state_t s, logic dir);
    case (s)
      ST_CMD:  return PH_CMD;
      ST_DATA: return {1'b0, dir, 1'b0};
      ST_STAT: return PH_STAT;
      ST_MSG:  return PH_MIN;
      default: return PH_FREE;
    endcase
  endfunction

  always_comb begin
    state_d = state_q;
    nxt_d   = nxt_q;
    lines_d = lines_q;
    bsy_d   = bsy_q;
    bad_d   = bad_q;
    clen_d  = clen_q;
    dlen_d  = dlen_q;
    dir_d   = dir_q;
    cnt_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sel_done_i) begin
          state_d = ST_CMD;
          lines_d = PH_CMD;
          bsy_d   = 1'b1;
          bad_d   = 1'b0;
          cnt_clr = 1'b1;
        end
      end
      ST_CMD: begin
        if (byte_done) begin
          if (first_byte) begin
            clen_d = dec_len;
            bad_d  = !dec_ok;
          end
          if (last_cmd) begin
            dlen_d  = be_len_i;
            dir_d   = be_dir_in_i;
            state_d = ST_GAP;
            nxt_d   = (bad_now || be_len_i == '0) ? ST_STAT : ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (byte_done && last_data) begin
          state_d = ST_GAP;
          nxt_d   = ST_STAT;
        end
      end
      ST_STAT: begin
        if (byte_done) begin
          state_d = ST_GAP;
          nxt_d   = ST_MSG;
        end
      end
      ST_MSG: begin
        if (byte_done) begin
          state_d = ST_GAP;
          nxt_d   = ST_IDLE;
        end
      end
      ST_GAP: begin
        if (!ack_i) begin
          state_d = nxt_q;
          lines_d = lines_of(nxt_q, dir_q);
          bsy_d   = (nxt_q != ST_IDLE);
          cnt_clr = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      nxt_q   <= ST_IDLE;
      lines_q <= PH_FREE;
      bsy_q   <= 1'b0;
      bad_q   <= 1'b0;
      clen_q  <= '0;
      dlen_q  <= '0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      nxt_q   <= nxt_d;
      lines_q <= lines_d;
      bsy_q   <= bsy_d;
      bad_q   <= bad_d;
      clen_q  <= clen_d;
      dlen_q  <= dlen_d;
      dir_q   <= dir_d;
    end
  end

  always_comb begin
    xfer_tx_o = MSG_DONE;
    if (state_q == ST_STAT) begin
      xfer_tx_o = bad_q ? STS_CHECK : be_status_i;
    end
  end

  assign bsy_o = bsy_q;
  assign cd_o  = lines_q[2];
  assign io_o  = lines_q[1];
  assign msg_o = lines_q[0];

  // R9: phase lines move only after a cycle with ACK negated
  p_lines_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({cd_o, io_o, msg_o}) |-> !$past(ack_i));

  // R8: a free bus shows no phase and requests no byte
  p_free_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bsy_o |-> ({cd_o, io_o, msg_o} == PH_FREE && !xfer_go_o));

  // R2: taking the bus always opens with the command phase
  p_cmd_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy_o) |-> ({cd_o, io_o, msg_o} == PH_CMD));

  // R5: the data byte count never passes the sampled length
  p_data_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (cnt < dlen_q));

  // R3: past the opcode the command count stays below the decoded length
  p_cmd_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMD && cnt != '0) |-> (cnt < LEN_W'(clen_q)));

endmodule

// File: tb/tb_tpseq_top.sv
module tb_tpseq_top;

  localparam int CLK_PER = 10;
  localparam int LEN_W   = 16;
  localparam int NVEC    = 8;

  // {opcode, 7'b0 + dir, len, status, ack hold cycles}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h08, 8'h01, 8'd4, 8'h00, 8'd1},
    {8'h2A, 8'h00, 8'd3, 8'h00, 8'd2},
    {8'h5A, 8'h01, 8'd0, 8'h02, 8'd1},
    {8'hA8, 8'h01, 8'd2, 8'h00, 8'd3},
    {8'h60, 8'h01, 8'd5, 8'h00, 8'd1},
    {8'hE0, 8'h00, 8'd2, 8'h00, 8'd2},
    {8'h12, 8'h01, 8'd1, 8'h02, 8'd3},
    {8'h1F, 8'h00, 8'd0, 8'h00, 8'd1}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             sel_done_i;
  logic             ack_i;
  logic             xfer_done_i;
  logic [7:0]       xfer_rx_i;
  logic             be_dir_in_i;
  logic [LEN_W-1:0] be_len_i;
  logic [7:0]       be_status_i;
  logic             xfer_go_o;
  logic [7:0]       xfer_tx_o;
  logic             bsy_o;
  logic             cd_o;
  logic             io_o;
  logic             msg_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  tpseq_top #(.LEN_W(LEN_W)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_done_i  (sel_done_i),
    .ack_i       (ack_i),
    .xfer_done_i (xfer_done_i),
    .xfer_rx_i   (xfer_rx_i),
    .be_dir_in_i (be_dir_in_i),
    .be_len_i    (be_len_i),
    .be_status_i (be_status_i),
    .xfer_go_o   (xfer_go_o),
    .xfer_tx_o   (xfer_tx_o),
    .bsy_o       (bsy_o),
    .cd_o        (cd_o),
    .io_o        (io_o),
    .msg_o       (msg_o)
  );

  always #(CLK_PER/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_cmd_len(input logic [7:0] op);
    case (op[7:5])
      3'd0:       return 6;
      3'd1, 3'd2: return 10;
      3'd5:       return 12;
      default:    return 1;
    endcase
  endfunction

  task automatic run_vec(input logic [7:0] op, input logic dir, input int len,
                         input logic [7:0] st, input int hold);
    int n_cmd = 0, n_din = 0, n_dout = 0, n_stat = 0, n_msg = 0;
    int bad_hold = 0;
    logic [7:0] stv = 8'hFF, msv = 8'hFF;
    logic [2:0] ph;
    bit bad_grp;
    int e_cmd;
    bad_grp     = (exp_cmd_len(op) == 1);
    e_cmd       = exp_cmd_len(op);
    be_dir_in_i = dir;
    be_len_i    = LEN_W'(len);
    be_status_i = st;
    @(negedge clk) sel_done_i = 1'b1;
    @(negedge clk) sel_done_i = 1'b0;
    chk(bsy_o && xfer_go_o && {cd_o, io_o, msg_o} == 3'b100, "R2 command phase entry",
        {bsy_o, xfer_go_o, cd_o, io_o, msg_o}, 5'b11100);
    for (int guard = 0; guard < 4000; guard++) begin
      if (!bsy_o) break;
      if (xfer_go_o) begin
        ph = {cd_o, io_o, msg_o};
        case (ph)
          3'b100: n_cmd++;
          3'b010: n_din++;
          3'b000: n_dout++;
          3'b110: begin n_stat++; stv = xfer_tx_o; end
          3'b111: begin n_msg++;  msv = xfer_tx_o; end
          default: ;
        endcase
        xfer_rx_i   = (ph == 3'b100 && n_cmd == 1) ? op : 8'h00;
        xfer_done_i = 1'b1;
        ack_i       = 1'b1;
        @(negedge clk) xfer_done_i = 1'b0;
        for (int h = 0; h < hold; h++) begin
          if ({cd_o, io_o, msg_o} != ph) bad_hold++;
          @(negedge clk);
        end
        ack_i = 1'b0;
      end
      @(negedge clk);
    end
    chk(n_cmd == e_cmd, bad_grp ? "R4 command ends at opcode" : "R3 command length",
        n_cmd, e_cmd);
    chk(n_din == ((dir && !bad_grp) ? len : 0) && n_dout == ((!dir && !bad_grp) ? len : 0),
        (len == 0 || bad_grp) ? "R6 data phase skipped" : "R5 data count and direction",
        {n_din[15:0], n_dout[15:0]},
        {16'((dir && !bad_grp) ? len : 0), 16'((!dir && !bad_grp) ? len : 0)});
    chk(n_stat == 1 && stv == (bad_grp ? 8'h02 : st),
        bad_grp ? "R4 check condition status" : "R7 status byte",
        stv, bad_grp ? 8'h02 : st);
    chk(n_msg == 1 && msv == 8'h00, "R8 command complete message", msv, 0);
    chk({bsy_o, cd_o, io_o, msg_o, xfer_go_o} == 5'b0, "R8 bus free after message",
        {bsy_o, cd_o, io_o, msg_o, xfer_go_o}, 0);
    chk(bad_hold == 0, "R9 lines held while ACK asserted", bad_hold, 0);
  endtask

  initial begin
    rst_n       = 1'b0;
    sel_done_i  = 1'b0;
    ack_i       = 1'b0;
    xfer_done_i = 1'b0;
    xfer_rx_i   = 8'h00;
    be_dir_in_i = 1'b0;
    be_len_i    = '0;
    be_status_i = 8'h00;
    repeat (3) @(negedge clk);
    chk({bsy_o, cd_o, io_o, msg_o, xfer_go_o} == 5'b0, "R1 outputs during reset",
        {bsy_o, cd_o, io_o, msg_o, xfer_go_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({bsy_o, cd_o, io_o, msg_o, xfer_go_o} == 5'b0, "R1 outputs after reset",
        {bsy_o, cd_o, io_o, msg_o, xfer_go_o}, 0);

    for (int v = 0; v < NVEC; v++) begin
      run_vec(VEC[v][39:32], VEC[v][24], int'(VEC[v][23:16]),
              VEC[v][15:8], int'(VEC[v][7:0]));
      repeat (2) @(negedge clk);
    end

    // R9 directed: ACK held long after the last command byte keeps the command lines
    run_vec(8'h00, 1'b1, 2, 8'h00, 12);
    // R6 directed: zero-length transfer on a ten-byte command
    run_vec(8'h28, 1'b0, 0, 8'h02, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule